// File: doc/BRIEF.md
# Register-Mapped SPI Master with Byte Queues

This block is a SPI master that a processor drives through a small bank of 32-bit registers. Software queues outgoing bytes in a transmit queue and picks up incoming bytes from a separate receive queue. Between the two queues sits a full-duplex byte shifter. It runs SPI mode 0: the clock idles low, MOSI changes on the falling edge and MISO is sampled on the rising edge. For every byte it sends, it collects one byte from the slave.

A hold bit in the control register stops the shifter from taking new bytes. While the hold bit is set, software can fill the queue and then release the whole burst with one control write. Chip-select lines are driven straight from a slave-select register and are active low. A keyed write restores every register and empties both queues. The overrun event leaves the block as a one-cycle pulse, and interrupt gathering is done elsewhere.

Top module: `spim_core`

## Requirements
- R1: After reset, the control register reads 0x100 (only the hold bit set) and the status register reads 0x5. Every chip-select output is high and SCLK is low.
- R2: Word addresses are: key reset 0x40, control 0x60, status 0x64, transmit data 0x68, receive data 0x6C, slave select 0x70. Status bits are: bit 0 receive empty, bit 1 receive full, bit 2 transmit empty, bit 3 transmit full.
- R3: In a control write, bit 5 empties the transmit queue and bit 6 empties the receive queue. Neither bit is stored, and both read back as 0.
- R4: Writing 0xA to the key reset address restores the reset state of all registers and empties both queues. Any other value written there changes nothing.
- R5: Chip-select output i equals bit i of the slave-select register.
- R6: While control bit 8 (hold) is set, no byte is shifted and queued bytes stay queued. Clearing the hold bit sends every queued byte in write order.
- R7: Each byte goes out MSB first in mode 0, with exactly 8 SCLK pulses per byte. SCLK stays low when the shifter is idle, and only one byte is in flight at a time.
- R8: Each byte that is sent pushes the byte sampled from MISO into the receive queue, in transfer order.
- R9: A byte that arrives while the receive queue is full is discarded, and overrun_evt pulses for one cycle.
- R10: Reading receive data while the receive queue is empty returns 0xDEADBEEF and leaves the queue unchanged.
- R11: A transmit write while the transmit queue is full is dropped, and the status register shows transmit full.
- R12: Writes to the status register have no effect.
- R13: Each queue holds FIFO_DEPTH bytes (256 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (pops receive data) |
| addr | input | ADDR_W | Byte address, word aligned |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the cycle of rd_en |
| sclk | output | 1 | SPI clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NUM_SS | Active-low chip selects |
| overrun_evt | output | 1 | One-cycle pulse when a received byte is discarded |

## Verification
A queue pointer or occupancy count that goes wrong shows up at the status register as soon as it is read. Within one byte time it also shows up on MOSI, either as a byte out of order, a repeated byte or a missing byte. A shifter with a bad bit counter or the wrong clock edge corrupts the very next frame, which the bench-side slave sees at once. The same fault appears again when the receive queue is read. A hold gate that leaks shows up as SCLK activity while the hold bit is set. A full-flag error appears either as a missing overrun pulse at the 257th transfer or as a stray 0xEE byte on MOSI.

// File: rtl/spim_pkg.sv
package spim_pkg;
   localparam int BYTE_W = 8;

   // word indices (byte address >> 2)
   localparam logic [4:0] W_KEYRST = 5'h10;
   localparam logic [4:0] W_CTRL   = 5'h18;
   localparam logic [4:0] W_STAT   = 5'h19;
   localparam logic [4:0] W_TXD    = 5'h1A;
   localparam logic [4:0] W_RXD    = 5'h1B;
   localparam logic [4:0] W_SSEL   = 5'h1C;

   localparam int CB_TXCLR = 5;
   localparam int CB_RXCLR = 6;
   localparam int CB_HOLD  = 8;

   localparam int SB_RXEMPTY = 0;
   localparam int SB_RXFULL  = 1;
   localparam int SB_TXEMPTY = 2;
   localparam int SB_TXFULL  = 3;

   localparam logic [31:0] KEY_VALUE   = 32'h0000_000A;
   localparam logic [31:0] EMPTY_WORD  = 32'hDEAD_BEEF;
   localparam logic [31:0] CTRL_RESET  = 32'h0000_0100;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 256,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          push,
   input  logic          pop,
   input  logic [W-1:0]  din,
   output logic [W-1:0]  dout,
   output logic [CW-1:0] count,
   output logic          empty,
   output logic          full
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("spim_fifo: DEPTH must be a power of two, at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("spim_fifo: W must be positive");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic          do_push, do_pop;

   assign empty   = (count == '0);
   assign full    = (count == CW'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push && !clr) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (clr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   // R11 / R13: a push into a full queue leaves it exactly full
   a_r11_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop && !clr) |=> (count == CW'(DEPTH)));
   a_r13_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (count <= CW'(DEPTH)));
   a_r10_pop_empty_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !push && !clr) |=> empty);
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
   parameter int DW       = 8,
   parameter int CLK_HALF = 2,
   localparam int CNT_W   = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1,
   localparam int BIT_W   = $clog2(DW)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          srst,
   input  logic          start,
   input  logic [DW-1:0] tx_byte,
   input  logic          miso,
   output logic          busy,
   output logic          sclk,
   output logic          mosi,
   output logic          done,
   output logic [DW-1:0] rx_byte
);
   if (CLK_HALF < 1) begin : g_bad_half
      $error("spim_shifter: CLK_HALF must be at least 1");
   end
   if (DW < 2) begin : g_bad_dw
      $error("spim_shifter: DW must be at least 2");
   end

   logic [DW-1:0]    tx_sr, rx_sr;
   logic [BIT_W-1:0] bit_n;
   logic             tick;

   // half-period timer: a plain strobe when every cycle is an edge
   if (CLK_HALF == 1) begin : g_fast
      assign tick = 1'b1;
   end else begin : g_div
      logic [CNT_W-1:0] half_cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          half_cnt <= '0;
         else if (srst || !busy)              half_cnt <= '0;
         else if (half_cnt == CNT_W'(CLK_HALF - 1)) half_cnt <= '0;
         else                                 half_cnt <= half_cnt + 1'b1;
      end
      assign tick = (half_cnt == CNT_W'(CLK_HALF - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         sclk  <= 1'b0;
         done  <= 1'b0;
         tx_sr <= '0;
         rx_sr <= '0;
         bit_n <= '0;
      end else if (srst) begin
         busy  <= 1'b0;
         sclk  <= 1'b0;
         done  <= 1'b0;
         tx_sr <= '0;
         rx_sr <= '0;
         bit_n <= '0;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (start) begin
               busy  <= 1'b1;
               tx_sr <= tx_byte;
               bit_n <= '0;
               sclk  <= 1'b0;
            end
         end else if (tick) begin
            sclk <= ~sclk;
            if (!sclk) begin
               rx_sr <= {rx_sr[DW-2:0], miso};
            end else if (bit_n == BIT_W'(DW - 1)) begin
               busy <= 1'b0;
               done <= 1'b1;
            end else begin
               tx_sr <= {tx_sr[DW-2:0], 1'b0};
               bit_n <= bit_n + 1'b1;
            end
         end
      end
   end

   assign mosi    = tx_sr[DW-1];
   assign rx_byte = rx_sr;

   // R7: clock idles low, a frame ends only from an active transfer
   a_r7_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sclk);
   a_r7_done_ends_frame: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(busy) && !busy));
   a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !srst) |=> (busy || done));
endmodule

// File: rtl/spim_core.sv
module spim_core #(
   parameter int ADDR_W     = 8,
   parameter int NUM_SS     = 4,
   parameter int FIFO_DEPTH = 256,
   parameter int CLK_HALF   = 2,
   localparam int CNT_W     = $clog2(FIFO_DEPTH) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   output logic              sclk,
   output logic              mosi,
   input  logic              miso,
   output logic [NUM_SS-1:0] ss_n,
   output logic              overrun_evt
);
   import spim_pkg::*;

   if (ADDR_W < 7) begin : g_bad_addr
      $error("spim_core: ADDR_W must reach word 0x1C");
   end
   if (NUM_SS < 1 || NUM_SS > 32) begin : g_bad_ss
      $error("spim_core: NUM_SS must be 1..32");
   end

   logic [ADDR_W-3:0] word;
   logic              hit_key, hit_ctrl, hit_txd, hit_rxd, hit_ssel, hit_stat;
   logic              key_rst;
   logic [31:0]       ctrl_q;
   logic [NUM_SS-1:0] ssel_q;
   logic              hold;

   assign word     = addr[ADDR_W-1:2];
   assign hit_key  = (word == (ADDR_W-2)'(W_KEYRST));
   assign hit_ctrl = (word == (ADDR_W-2)'(W_CTRL));
   assign hit_stat = (word == (ADDR_W-2)'(W_STAT));
   assign hit_txd  = (word == (ADDR_W-2)'(W_TXD));
   assign hit_rxd  = (word == (ADDR_W-2)'(W_RXD));
   assign hit_ssel = (word == (ADDR_W-2)'(W_SSEL));
   assign key_rst  = wr_en && hit_key && (wdata == KEY_VALUE);
   assign hold     = ctrl_q[CB_HOLD];

   // control and select registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= CTRL_RESET;
         ssel_q <= '1;
      end else if (key_rst) begin
         ctrl_q <= CTRL_RESET;
         ssel_q <= '1;
      end else if (wr_en) begin
         if (hit_ctrl) begin
            ctrl_q           <= wdata;
            ctrl_q[CB_TXCLR] <= 1'b0;
            ctrl_q[CB_RXCLR] <= 1'b0;
         end
         if (hit_ssel) ssel_q <= wdata[NUM_SS-1:0];
      end
   end

   assign ss_n = ssel_q;

   // queues
   logic [7:0]       tx_head, rx_head, sh_rx;
   logic [CNT_W-1:0] tx_cnt, rx_cnt;
   logic             tx_empty, tx_full, rx_empty, rx_full;
   logic             tx_clr, rx_clr, tx_push, rx_push, rx_pop;
   logic             sh_start, sh_busy, sh_done;

   assign tx_clr   = key_rst || (wr_en && hit_ctrl && wdata[CB_TXCLR]);
   assign rx_clr   = key_rst || (wr_en && hit_ctrl && wdata[CB_RXCLR]);
   assign tx_push  = wr_en && hit_txd;
   assign rx_push  = sh_done && !rx_full;
   assign rx_pop   = rd_en && hit_rxd && !rx_empty;
   assign sh_start = !sh_busy && !hold && !tx_empty && !tx_clr && !key_rst;

   spim_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .clr(tx_clr),
      .push(tx_push), .pop(sh_start), .din(wdata[BYTE_W-1:0]),
      .dout(tx_head), .count(tx_cnt), .empty(tx_empty), .full(tx_full)
   );

   spim_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .clr(rx_clr),
      .push(rx_push), .pop(rx_pop), .din(sh_rx),
      .dout(rx_head), .count(rx_cnt), .empty(rx_empty), .full(rx_full)
   );

   spim_shifter #(.DW(BYTE_W), .CLK_HALF(CLK_HALF)) u_shift (
      .clk(clk), .rst_n(rst_n), .srst(key_rst), .start(sh_start),
      .tx_byte(tx_head), .miso(miso), .busy(sh_busy), .sclk(sclk),
      .mosi(mosi), .done(sh_done), .rx_byte(sh_rx)
   );

   // overrun event
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       overrun_evt <= 1'b0;
      else if (key_rst) overrun_evt <= 1'b0;
      else              overrun_evt <= sh_done && rx_full && !rx_clr;
   end

   // read mux
   logic [31:0] stat_word;
   always_comb begin
      stat_word             = '0;
      stat_word[SB_RXEMPTY] = rx_empty;
      stat_word[SB_RXFULL]  = rx_full;
      stat_word[SB_TXEMPTY] = tx_empty;
      stat_word[SB_TXFULL]  = tx_full;
   end

   always_comb begin
      rdata = '0;
      if (hit_ctrl)      rdata = ctrl_q;
      else if (hit_stat) rdata = stat_word;
      else if (hit_ssel) rdata[NUM_SS-1:0] = ssel_q;
      else if (hit_rxd)  rdata = rx_empty ? EMPTY_WORD : {24'h0, rx_head};
   end

   // R4: a keyed write deselects every slave on the next cycle
   a_r4_key_deselects: assert property (@(posedge clk) disable iff (!rst_n)
      key_rst |=> (ss_n == '1 && rx_cnt == '0 && tx_cnt == '0));
   // R6: with the hold bit set, an idle shifter stays idle
   a_r6_hold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && !sh_busy) |=> !sh_busy);
   // R9: an overrun pulse follows a finished byte meeting a full queue
   a_r9_overrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
      overrun_evt |-> ($past(sh_done) && $past(rx_full)));
   // R10: reading an empty receive queue leaves it empty
   a_r10_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && hit_rxd && rx_empty && !sh_done) |=> rx_empty);
   // R3: clear bits never read back
   a_r3_clear_bits_unstored: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && hit_ctrl) |=> (!ctrl_q[CB_TXCLR] && !ctrl_q[CB_RXCLR]));
endmodule

// File: tb/sim_spim_core.sv
module sim_spim_core;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        sclk, mosi, miso;
   logic [3:0]  ss_n;
   logic        overrun_evt;

   int nchk = 0, nerr = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   spim_core u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .sclk(sclk), .mosi(mosi), .miso(miso),
      .ss_n(ss_n), .overrun_evt(overrun_evt)
   );

   // scoreboard queues
   logic [7:0] exp_mosi[$];
   logic [7:0] exp_rx[$];

   function automatic logic [7:0] slave_byte(int k);
      return 8'(k * 29 + 8'h5A);
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // slave model and MOSI monitor (R7, R8)
   logic [7:0] s_rx, s_tx;
   int         s_bits = 0, s_idx = 0, sclk_rises = 0;
   bit         s_load = 0;
   initial begin s_tx = slave_byte(0); miso = s_tx[7]; end

   always @(posedge sclk) begin
      sclk_rises++;
      s_rx = {s_rx[6:0], mosi};
      s_bits++;
      if (s_bits == 8) begin
         s_bits = 0;
         nchk++;
         if (exp_mosi.size() == 0) begin
            nerr++;
            $display("FAIL R6 unexpected MOSI byte actual=%h expected=none", s_rx);
         end else begin
            logic [7:0] e;
            e = exp_mosi.pop_front();
            if (s_rx !== e) begin
               nerr++;
               $display("FAIL R7 MOSI byte actual=%h expected=%h", s_rx, e);
            end
         end
         exp_rx.push_back(slave_byte(s_idx));
         s_idx++;
         s_load = 1;
      end
   end

   always @(negedge sclk) begin
      if (s_load) begin s_tx = slave_byte(s_idx); s_load = 0; end
      else s_tx = {s_tx[6:0], 1'b0};
      miso = s_tx[7];
   end

   int ovr_cnt = 0;
   always @(negedge clk) if (rst_n && overrun_evt) ovr_cnt++;

   task automatic bus_wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic bus_rd(logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      #1 d = rdata;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic send(logic [7:0] b);
      exp_mosi.push_back(b);
      bus_wr(8'h68, {24'h0, b});
   endtask

   task automatic wait_clk(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   endtask

   initial begin
      #(10 * 150000);
      nchk++; nerr++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      int r0;
      wait_clk(3);
      rst_n = 1'b1;
      wait_clk(2);

      // R1 reset state
      bus_rd(8'h60, v); chk("R1 control reset", v, 32'h100);
      bus_rd(8'h64, v); chk("R1 status reset (R2 bits)", v, 32'h5);
      chk("R1 ss_n reset", {28'h0, ss_n}, 32'hF);
      chk("R1 sclk idle", {31'h0, sclk}, 32'h0);

      // R5 slave select
      bus_wr(8'h70, 32'hA);
      chk("R5 ss_n follows select", {28'h0, ss_n}, 32'hA);
      bus_rd(8'h70, v); chk("R5 select readback", v, 32'hA);

      // R4 wrong key does nothing, right key restores
      bus_wr(8'h40, 32'h5);
      chk("R4 bad key ignored", {28'h0, ss_n}, 32'hA);
      bus_wr(8'h60, 32'h0);
      bus_wr(8'h40, 32'hA);
      chk("R4 key restores select", {28'h0, ss_n}, 32'hF);
      bus_rd(8'h60, v); chk("R4 key restores control", v, 32'h100);

      // R12 status write ignored
      bus_wr(8'h64, 32'hF);
      bus_rd(8'h64, v); chk("R12 status unchanged", v, 32'h5);

      // R6 hold keeps bytes queued
      r0 = sclk_rises;
      send(8'hA5); send(8'h3C); send(8'h81);
      wait_clk(200);
      chk("R6 no clock while held", sclk_rises, r0);
      bus_rd(8'h64, v); chk("R6 bytes still queued", v, 32'h1);
      bus_wr(8'h60, 32'h0);
      wait_clk(200);
      chk("R7 eight pulses per byte", sclk_rises - r0, 24);
      bus_rd(8'h64, v); chk("R8 rx holds data tx drained", v, 32'h4);
      for (int i = 0; i < 3; i++) begin
         bus_rd(8'h6C, v);
         chk("R8 received byte", v, {24'h0, exp_rx.pop_front()});
      end
      bus_rd(8'h6C, v); chk("R10 empty read sentinel", v, 32'hDEADBEEF);
      bus_rd(8'h64, v); chk("R10 queue unchanged", v, 32'h5);

      // R3 queue clear bits
      bus_wr(8'h60, 32'h100);
      send(8'h11); send(8'h22);
      bus_wr(8'h60, 32'h160);
      exp_mosi.delete();
      bus_rd(8'h60, v); chk("R3 clear bits not stored", v, 32'h100);
      bus_rd(8'h64, v); chk("R3 tx queue emptied", v, 32'h5);
      r0 = sclk_rises;
      bus_wr(8'h60, 32'h0);
      wait_clk(100);
      chk("R3 cleared bytes never sent", sclk_rises, r0);
      send(8'h77);
      wait_clk(100);
      bus_rd(8'h64, v); chk("R3 rx before clear", v, 32'h4);
      bus_wr(8'h60, 32'h40);
      exp_rx.delete();
      bus_rd(8'h64, v); chk("R3 rx queue emptied", v, 32'h5);

      // R11 / R13 full transmit queue, R9 overrun
      bus_wr(8'h60, 32'h100);
      for (int i = 0; i < 256; i++) send(8'(i * 7 + 3));
      bus_rd(8'h64, v); chk("R13 tx full at 256 (R11 flag)", v, 32'h9);
      bus_wr(8'h68, 32'hEE);
      bus_rd(8'h64, v); chk("R11 extra write dropped", v, 32'h9);
      bus_wr(8'h60, 32'h0);
      wait_clk(9000);
      bus_rd(8'h64, v); chk("R13 rx full after 256", v, 32'h6);
      chk("R9 no overrun yet", ovr_cnt, 0);
      send(8'h5C);
      wait_clk(100);
      chk("R9 one overrun pulse", ovr_cnt, 1);
      for (int i = 0; i < 256; i++) begin
         bus_rd(8'h6C, v);
         chk("R9 kept bytes in order", v, {24'h0, exp_rx.pop_front()});
      end
      chk("R9 one byte discarded", exp_rx.size(), 1);
      bus_rd(8'h6C, v); chk("R10 sentinel after drain", v, 32'hDEADBEEF);
      chk("R6 all queued bytes sent", exp_mosi.size(), 0);
      finish_run();
   end
endmodule